// File: doc/BRIEF.md
# SPI channel FIFO with thresholds and word counter

This block is the data buffer that sits between a host-side data path and one SPI serial engine. A single store of 64 byte-wide entries serves both directions. When only one direction is enabled, that direction gets the whole store. When both are enabled, each direction gets one half. The host pushes transmit words and pops receive words over valid/ready ports. The serial engine pops transmit words and pushes receive words over its own valid/ready ports.

A 32-bit level register is written over a simple register bus. It holds two thresholds, both encoded as the level minus one, and a transfer word limit. From the thresholds the block derives two request lines, one per direction, that a DMA controller or an interrupt controller can use to refill or drain the buffer. The word counter counts the words moved on the serial side and raises a one-cycle end-of-count pulse each time the programmed number is reached.

Transmit use of the buffer is granted to a channel only while exactly one of the per-channel transmit enables is set. Any change of the enable inputs flushes both directions.

Top module: `spi_lvl_buf`

## Requirements
- R1: After reset both directions are empty and not full, both request lines and the end-of-count pulse are low, and all level fields read as zero.
- R2: A register write loads the almost-empty threshold from bits 5:0, the almost-full threshold from bits 13:8 and the word limit from bits 31:16. The new values govern the requests and the counter from the next cycle.
- R3: The transmit direction is active only while exactly one bit of `tx_fifo_en_i` is set, sampled one cycle earlier. Otherwise `wr_ready_o` is low and the transmit side stays empty.
- R4: Each active direction holds 64 words when it is the only active direction. It holds 32 words when both are active, and the receive half then lives in the upper half of the store.
- R5: Each direction returns words in the order they were accepted. A push and a pop in the same cycle are both honoured.
- R6: A push into a full direction is not accepted (`wr_ready_o` or `eng_rx_ready_o` is low), and a pop from an empty direction is not offered (the valid output is low). The state is unchanged in both cases.
- R7: `tx_req_o` is high exactly when transmit is active and the free space is at least the almost-empty field plus one.
- R8: `rx_req_o` is high exactly when receive is active and the fill level is at least the almost-full field plus one.
- R9: The counted words are engine transmit pops when transmit is active, and engine receive pushes otherwise. `eow_o` pulses in the cycle after the word that makes the count equal the limit, and counting then restarts from zero. A register write clears the count.
- R10: A word limit of zero disables counting, and `eow_o` never rises.
- R11: Any change of `tx_fifo_en_i` or `rx_fifo_en_i` empties both directions and clears the word count by the next cycle.
- R12: `tx_empty_o`, `tx_full_o`, `rx_empty_o` and `rx_full_o` reflect the fill level of each direction against its current capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Level register write strobe |
| reg_wdata_i | input | 32 | Level register write data |
| tx_fifo_en_i | input | NCH | Per-channel transmit buffer enables |
| rx_fifo_en_i | input | 1 | Receive buffer enable |
| wr_valid_i | input | 1 | Host transmit word valid |
| wr_data_i | input | DW | Host transmit word |
| wr_ready_o | output | 1 | Transmit side can accept |
| eng_tx_valid_o | output | 1 | Transmit word available to engine |
| eng_tx_data_o | output | DW | Transmit word to engine |
| eng_tx_ready_i | input | 1 | Engine takes transmit word |
| eng_rx_valid_i | input | 1 | Engine receive word valid |
| eng_rx_data_i | input | DW | Engine receive word |
| eng_rx_ready_o | output | 1 | Receive side can accept |
| rd_valid_o | output | 1 | Receive word available to host |
| rd_data_o | output | DW | Receive word to host |
| rd_ready_i | input | 1 | Host takes receive word |
| tx_empty_o | output | 1 | Transmit side empty |
| tx_full_o | output | 1 | Transmit side full |
| rx_empty_o | output | 1 | Receive side empty |
| rx_full_o | output | 1 | Receive side full |
| tx_req_o | output | 1 | Transmit refill request |
| rx_req_o | output | 1 | Receive drain request |
| eow_o | output | 1 | End-of-word-count pulse |

## Verification
The assertions check these properties on every cycle:
- each fill count stays within its capacity, and no pop reaches an empty side;
- both counts are bounded by the half size while both directions run;
- a configuration change leaves both sides empty;
- a transmit enable pattern without exactly one bit set leaves transmit empty;
- a zero limit never produces an end-of-count pulse.

Data ordering, the exact threshold crossings, the half-store layout under traffic in both directions and the number of end-of-count pulses over a window can only be shown by the bench's scenarios. The bench compares each of these against its queue model on every clock.

// File: rtl/spi_lvl_pkg.sv
package spi_lvl_pkg;
  localparam int unsigned TH_W = 6;
  localparam int unsigned WC_W = 16;

  typedef struct packed {
    logic [WC_W-1:0] wlim;
    logic [TH_W-1:0] afl;
    logic [TH_W-1:0] ael;
  } lvl_t;

  // register field positions; the bus layout is fixed
  localparam int unsigned AEL_LSB = 0;
  localparam int unsigned AFL_LSB = 8;
  localparam int unsigned WC_LSB  = 16;
endpackage

// File: rtl/spi_lvl_regs.sv
module spi_lvl_regs
  import spi_lvl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output lvl_t        lvl_o
);
  lvl_t lvl_q;
  logic unused_rsv;

  assign unused_rsv = ^{wdata_i[15:14], wdata_i[7:6]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (we_i) begin
      lvl_q.ael  <= wdata_i[AEL_LSB +: TH_W];
      lvl_q.afl  <= wdata_i[AFL_LSB +: TH_W];
      lvl_q.wlim <= wdata_i[WC_LSB +: WC_W];
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/spi_lvl_ptr.sv
module spi_lvl_ptr #(
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       half_i,
  input  logic                       push_i,
  input  logic                       pop_i,
  output logic [$clog2(DEPTH)-1:0]   wr_idx_o,
  output logic [$clog2(DEPTH)-1:0]   rd_idx_o,
  output logic [$clog2(DEPTH):0]     cnt_o,
  output logic                       empty_o,
  output logic                       full_o
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned HALF = DEPTH / 2;

  logic [AW-1:0] wp_q, rp_q, mask;
  logic [AW:0]   cnt_q, cap;

  assign mask = half_i ? AW'(HALF - 1) : AW'(DEPTH - 1);
  assign cap  = half_i ? (AW+1)'(HALF) : (AW+1)'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q + 1'b1) & mask;
      if (pop_i)  rp_q <= (rp_q + 1'b1) & mask;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_idx_o = wp_q;
  assign rd_idx_o = rp_q;
  assign cnt_o    = cnt_q;
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == cap);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/spi_lvl_mem.sv
module spi_lvl_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8
) (
  input  logic                     clk_i,
  input  logic                     we_a_i,
  input  logic [$clog2(DEPTH)-1:0] wa_a_i,
  input  logic [DW-1:0]            wd_a_i,
  input  logic                     we_b_i,
  input  logic [$clog2(DEPTH)-1:0] wa_b_i,
  input  logic [DW-1:0]            wd_b_i,
  input  logic [$clog2(DEPTH)-1:0] ra_a_i,
  output logic [DW-1:0]            rd_a_o,
  input  logic [$clog2(DEPTH)-1:0] ra_b_i,
  output logic [DW-1:0]            rd_b_o
);
  logic [DW-1:0] mem [DEPTH];

  // the two write ports target disjoint regions whenever both are live
  always_ff @(posedge clk_i) begin
    if (we_a_i) mem[wa_a_i] <= wd_a_i;
    if (we_b_i) mem[wa_b_i] <= wd_b_i;
  end

  assign rd_a_o = mem[ra_a_i];
  assign rd_b_o = mem[ra_b_i];
endmodule

// File: rtl/spi_lvl_wcnt.sv
module spi_lvl_wcnt #(
  parameter int unsigned WC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            word_i,
  input  logic [WC_W-1:0] lim_i,
  output logic            eow_o
);
  logic [WC_W-1:0] cnt_q;
  logic            eow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      eow_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      eow_q <= 1'b0;
    end else if (word_i && lim_i != '0) begin
      if (cnt_q + 1'b1 == lim_i) begin
        cnt_q <= '0;
        eow_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        eow_q <= 1'b0;
      end
    end else begin
      eow_q <= 1'b0;
    end
  end

  assign eow_o = eow_q;

  // R10
  no_eow_unlimited_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lim_i) == '0) |-> !eow_q);
endmodule

// File: rtl/spi_lvl_buf.sv
module spi_lvl_buf
  import spi_lvl_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned NCH   = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [31:0]    reg_wdata_i,
  input  logic [NCH-1:0] tx_fifo_en_i,
  input  logic           rx_fifo_en_i,
  input  logic           wr_valid_i,
  input  logic [DW-1:0]  wr_data_i,
  output logic           wr_ready_o,
  output logic           eng_tx_valid_o,
  output logic [DW-1:0]  eng_tx_data_o,
  input  logic           eng_tx_ready_i,
  input  logic           eng_rx_valid_i,
  input  logic [DW-1:0]  eng_rx_data_i,
  output logic           eng_rx_ready_o,
  output logic           rd_valid_o,
  output logic [DW-1:0]  rd_data_o,
  input  logic           rd_ready_i,
  output logic           tx_empty_o,
  output logic           tx_full_o,
  output logic           rx_empty_o,
  output logic           rx_full_o,
  output logic           tx_req_o,
  output logic           rx_req_o,
  output logic           eow_o
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned HALF = DEPTH / 2;
  localparam int unsigned CW   = (AW + 2 > TH_W + 2) ? AW + 2 : TH_W + 2;

  lvl_t           lvl;
  logic [NCH-1:0] txsel_q;
  logic           rx_en_q;
  logic           tx_act, rx_act, both, cfg_chg;
  logic           tx_push, tx_pop, rx_push, rx_pop;
  logic [AW-1:0]  tx_wi, tx_ri, rx_wi, rx_ri, rx_base;
  logic [AW:0]    tx_cnt, rx_cnt, cap;
  logic           tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0]  tx_free;

  spi_lvl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .lvl_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txsel_q <= '0;
      rx_en_q <= 1'b0;
    end else begin
      txsel_q <= tx_fifo_en_i;
      rx_en_q <= rx_fifo_en_i;
    end
  end

  assign tx_act  = $onehot(txsel_q);
  assign rx_act  = rx_en_q;
  assign both    = tx_act && rx_act;
  assign cfg_chg = (tx_fifo_en_i != txsel_q) || (rx_fifo_en_i != rx_en_q);
  assign cap     = both ? (AW+1)'(HALF) : (AW+1)'(DEPTH);

  assign wr_ready_o     = tx_act && !tx_full;
  assign eng_tx_valid_o = tx_act && !tx_empty;
  assign eng_rx_ready_o = rx_act && !rx_full;
  assign rd_valid_o     = rx_act && !rx_empty;

  assign tx_push = wr_valid_i && wr_ready_o;
  assign tx_pop  = eng_tx_ready_i && eng_tx_valid_o;
  assign rx_push = eng_rx_valid_i && eng_rx_ready_o;
  assign rx_pop  = rd_ready_i && rd_valid_o;

  spi_lvl_ptr #(.DEPTH(DEPTH)) u_tx_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (cfg_chg),
    .half_i   (both),
    .push_i   (tx_push),
    .pop_i    (tx_pop),
    .wr_idx_o (tx_wi),
    .rd_idx_o (tx_ri),
    .cnt_o    (tx_cnt),
    .empty_o  (tx_empty),
    .full_o   (tx_full)
  );

  spi_lvl_ptr #(.DEPTH(DEPTH)) u_rx_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (cfg_chg),
    .half_i   (both),
    .push_i   (rx_push),
    .pop_i    (rx_pop),
    .wr_idx_o (rx_wi),
    .rd_idx_o (rx_ri),
    .cnt_o    (rx_cnt),
    .empty_o  (rx_empty),
    .full_o   (rx_full)
  );

  // receive region moves to the upper half when transmit shares the store
  assign rx_base = both ? AW'(HALF) : '0;

  spi_lvl_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .we_a_i (tx_push),
    .wa_a_i (tx_wi),
    .wd_a_i (wr_data_i),
    .we_b_i (rx_push),
    .wa_b_i (rx_wi | rx_base),
    .wd_b_i (eng_rx_data_i),
    .ra_a_i (tx_ri),
    .rd_a_o (eng_tx_data_o),
    .ra_b_i (rx_ri | rx_base),
    .rd_b_o (rd_data_o)
  );

  assign tx_free  = CW'(cap) - CW'(tx_cnt);
  assign tx_req_o = tx_act && (tx_free >= CW'(lvl.ael) + CW'(1));
  assign rx_req_o = rx_act && (CW'(rx_cnt) >= CW'(lvl.afl) + CW'(1));

  assign tx_empty_o = tx_empty;
  assign tx_full_o  = tx_full;
  assign rx_empty_o = rx_empty;
  assign rx_full_o  = rx_full;

  spi_lvl_wcnt #(.WC_W(WC_W)) u_wcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_chg || reg_we_i),
    .word_i (tx_act ? tx_pop : rx_push),
    .lim_i  (lvl.wlim),
    .eow_o  (eow_o)
  );

  // R11
  cfg_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> (tx_cnt == '0 && rx_cnt == '0));
  // R3
  tx_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$onehot(tx_fifo_en_i) |=> tx_empty_o);
  // R4
  half_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both |-> (tx_cnt <= (AW+1)'(HALF) && rx_cnt <= (AW+1)'(HALF)));
endmodule

// File: tb/sim_spi_lvl_buf.sv
`timescale 1ns/100ps
module sim_spi_lvl_buf;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int NCH   = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           reg_we_i = 1'b0;
  logic [31:0]    reg_wdata_i = '0;
  logic [NCH-1:0] tx_fifo_en_i = '0;
  logic           rx_fifo_en_i = 1'b0;
  logic           wr_valid_i = 1'b0;
  logic [DW-1:0]  wr_data_i = '0;
  logic           eng_tx_ready_i = 1'b0;
  logic           eng_rx_valid_i = 1'b0;
  logic [DW-1:0]  eng_rx_data_i = '0;
  logic           rd_ready_i = 1'b0;
  logic           wr_ready_o, eng_tx_valid_o, eng_rx_ready_o, rd_valid_o;
  logic [DW-1:0]  eng_tx_data_o, rd_data_o;
  logic           tx_empty_o, tx_full_o, rx_empty_o, rx_full_o;
  logic           tx_req_o, rx_req_o, eow_o;

  spi_lvl_buf #(.DEPTH(DEPTH), .DW(DW), .NCH(NCH)) u0 (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0]  txq[$], rxq[$];
  logic [NCH-1:0] m_txsel = '0;
  bit             m_rx = 0, m_eow = 0;
  int             m_ael = 0, m_afl = 0, m_wlim = 0, m_wc = 0, m_words = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int mcap();
    return ($onehot(m_txsel) && m_rx) ? DEPTH/2 : DEPTH;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      txq.delete(); rxq.delete();
      m_txsel = '0; m_rx = 0; m_eow = 0;
      m_ael = 0; m_afl = 0; m_wlim = 0; m_wc = 0;
    end else begin
      bit ta, tpush, tpop, rpush, rpop, word;
      int cp;
      ta    = $onehot(m_txsel);
      cp    = mcap();
      tpush = wr_valid_i && ta && txq.size() < cp;
      tpop  = eng_tx_ready_i && ta && txq.size() > 0;
      rpush = eng_rx_valid_i && m_rx && rxq.size() < cp;
      rpop  = rd_ready_i && m_rx && rxq.size() > 0;
      word  = ta ? tpop : rpush;
      if (tx_fifo_en_i != m_txsel || rx_fifo_en_i != m_rx) begin
        txq.delete(); rxq.delete();
        m_wc = 0; m_eow = 0;
        m_txsel = tx_fifo_en_i; m_rx = rx_fifo_en_i;
      end else begin
        if (tpop) void'(txq.pop_front());
        if (tpush) txq.push_back(wr_data_i);
        if (rpop) void'(rxq.pop_front());
        if (rpush) rxq.push_back(eng_rx_data_i);
        if (word) m_words++;
        if (reg_we_i) begin
          m_wc = 0; m_eow = 0;
        end else if (word && m_wlim != 0) begin
          if (m_wc + 1 == m_wlim) begin m_wc = 0; m_eow = 1; end
          else begin m_wc++; m_eow = 0; end
        end else begin
          m_eow = 0;
        end
      end
      if (reg_we_i) begin
        m_ael  = int'(reg_wdata_i[5:0]);
        m_afl  = int'(reg_wdata_i[13:8]);
        m_wlim = int'(reg_wdata_i[31:16]);
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit ta;
      int cp;
      ta = $onehot(m_txsel);
      cp = mcap();
      chk("R6", "wr_ready", int'(wr_ready_o), int'(ta && txq.size() < cp));
      chk("R6", "eng_rx_ready", int'(eng_rx_ready_o), int'(m_rx && rxq.size() < cp));
      chk("R6", "eng_tx_valid", int'(eng_tx_valid_o), int'(txq.size() > 0));
      chk("R6", "rd_valid", int'(rd_valid_o), int'(rxq.size() > 0));
      if (txq.size() > 0) chk("R5", "eng_tx_data", int'(eng_tx_data_o), int'(txq[0]));
      if (rxq.size() > 0) chk("R5", "rd_data", int'(rd_data_o), int'(rxq[0]));
      chk("R12", "tx_empty", int'(tx_empty_o), int'(txq.size() == 0));
      chk("R12", "tx_full", int'(tx_full_o), int'(txq.size() == cp));
      chk("R12", "rx_empty", int'(rx_empty_o), int'(rxq.size() == 0));
      chk("R12", "rx_full", int'(rx_full_o), int'(rxq.size() == cp));
      chk("R7", "tx_req", int'(tx_req_o), int'(ta && (cp - txq.size()) >= m_ael + 1));
      chk("R8", "rx_req", int'(rx_req_o), int'(m_rx && rxq.size() >= m_afl + 1));
      chk("R9", "eow", int'(eow_o), int'(m_eow));
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic lvl_wr(input int ael, input int afl, input int wl);
    reg_wdata_i = {wl[15:0], 2'b00, afl[5:0], 2'b00, ael[5:0]};
    reg_we_i = 1'b1; tick(); reg_we_i = 1'b0;
  endtask

  task automatic cfg(input logic [NCH-1:0] t, input logic r);
    tx_fifo_en_i = t; rx_fifo_en_i = r; tick(2);
  endtask

  task automatic idle();
    wr_valid_i = 0; eng_tx_ready_i = 0; eng_rx_valid_i = 0; rd_ready_i = 0;
  endtask

  initial begin
    int eows, w0;
    tick(3);
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk("R1", "tx_empty", int'(tx_empty_o), 1);
    chk("R1", "rx_empty", int'(rx_empty_o), 1);
    chk("R1", "full", int'(tx_full_o | rx_full_o), 0);
    chk("R1", "reqs", int'(tx_req_o | rx_req_o), 0);
    chk("R1", "eow", int'(eow_o), 0);

    // R2 fields and R7: free 64 >= 64 with ael=63
    lvl_wr(63, 7, 0);
    cfg(4'b0001, 1'b0);
    chk("R2", "tx_req at ael=63 empty", int'(tx_req_o), 1);
    wr_valid_i = 1; wr_data_i = 8'h11; tick(); wr_valid_i = 0;
    chk("R2", "tx_req at ael=63 one used", int'(tx_req_o), 0);

    // fill transmit to 64 and try past it
    lvl_wr(3, 7, 0);
    wr_valid_i = 1;
    for (int i = 0; i < 70; i++) begin wr_data_i = DW'(i * 3); tick(); end
    wr_valid_i = 0;
    chk("R4", "tx_full single dir", int'(tx_full_o), 1);
    chk("R6", "wr_ready when full", int'(wr_ready_o), 0);
    // mixed push/pop traffic
    for (int i = 0; i < 300; i++) begin
      wr_valid_i = ($urandom_range(0, 2) != 0); wr_data_i = DW'($urandom);
      eng_tx_ready_i = ($urandom_range(0, 1) != 0);
      tick();
    end
    idle(); eng_tx_ready_i = 1; tick(70); idle();
    chk("R6", "tx drained", int'(tx_empty_o), 1);

    // receive only
    cfg(4'b0000, 1'b1);
    eng_rx_valid_i = 1;
    for (int i = 0; i < 68; i++) begin eng_rx_data_i = DW'(i + 100); tick(); end
    eng_rx_valid_i = 0;
    chk("R4", "rx_full single dir", int'(rx_full_o), 1);
    for (int i = 0; i < 300; i++) begin
      eng_rx_valid_i = ($urandom_range(0, 1) != 0); eng_rx_data_i = DW'($urandom);
      rd_ready_i = ($urandom_range(0, 2) != 0);
      tick();
    end
    idle();

    // both directions share the store
    cfg(4'b0010, 1'b1);
    wr_valid_i = 1; eng_rx_valid_i = 1;
    for (int i = 0; i < 40; i++) begin
      wr_data_i = DW'(i); eng_rx_data_i = DW'(8'hC0 + i); tick();
    end
    idle();
    chk("R4", "tx_full half", int'(tx_full_o), 1);
    chk("R4", "rx_full half", int'(rx_full_o), 1);
    for (int i = 0; i < 400; i++) begin
      wr_valid_i = ($urandom_range(0, 1) != 0); wr_data_i = DW'($urandom);
      eng_tx_ready_i = ($urandom_range(0, 1) != 0);
      eng_rx_valid_i = ($urandom_range(0, 1) != 0); eng_rx_data_i = DW'($urandom);
      rd_ready_i = ($urandom_range(0, 1) != 0);
      tick();
    end
    idle();
    wr_valid_i = 1; eng_rx_valid_i = 1; tick(5); idle();

    // R11 change flushes
    cfg(4'b0011, 1'b0);
    chk("R11", "tx flushed", int'(tx_empty_o), 1);
    chk("R11", "rx flushed", int'(rx_empty_o), 1);
    // R3 two owners -> transmit inactive
    wr_valid_i = 1; tick(4); wr_valid_i = 0;
    chk("R3", "wr_ready two owners", int'(wr_ready_o), 0);
    chk("R3", "tx_empty two owners", int'(tx_empty_o), 1);

    // R9 transmit word count of 5
    cfg(4'b1000, 1'b0);
    lvl_wr(0, 0, 5);
    eows = 0; w0 = m_words;
    wr_valid_i = 1; eng_tx_ready_i = 1;
    for (int i = 0; i < 40; i++) begin wr_data_i = DW'(i); tick(); eows += int'(eow_o); end
    idle(); tick(); eows += int'(eow_o); tick();
    chk("R9", "eow pulses limit 5", eows, (m_words - w0) / 5);

    // R10 unlimited
    lvl_wr(0, 0, 0);
    eows = 0;
    wr_valid_i = 1; eng_tx_ready_i = 1;
    for (int i = 0; i < 40; i++) begin tick(); eows += int'(eow_o); end
    idle(); tick(2);
    chk("R10", "eow pulses limit 0", eows, 0);

    // R9 receive-side counting, limit 1 back to back
    cfg(4'b0000, 1'b1);
    lvl_wr(0, 0, 1);
    eows = 0; w0 = m_words;
    eng_rx_valid_i = 1; rd_ready_i = 1;
    for (int i = 0; i < 20; i++) begin eng_rx_data_i = DW'(i); tick(); eows += int'(eow_o); end
    idle(); tick(); eows += int'(eow_o); tick();
    chk("R9", "eow pulses rx limit 1", eows, m_words - w0);

    // random soak
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) == 0) begin
        tx_fifo_en_i = NCH'($urandom_range(0, 3) == 0 ? $urandom : (1 << $urandom_range(0, NCH-1)));
        rx_fifo_en_i = $urandom_range(0, 1) != 0;
      end
      reg_we_i = ($urandom_range(0, 199) == 0);
      reg_wdata_i = {16'($urandom_range(0, 7)), 2'b00, 6'($urandom), 2'b00, 6'($urandom)};
      wr_valid_i = ($urandom_range(0, 1) != 0); wr_data_i = DW'($urandom);
      eng_tx_ready_i = ($urandom_range(0, 1) != 0);
      eng_rx_valid_i = ($urandom_range(0, 1) != 0); eng_rx_data_i = DW'($urandom);
      rd_ready_i = ($urandom_range(0, 1) != 0);
      tick();
    end
    reg_we_i = 0; idle(); tick(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule